// File: doc/BRIEF.md
# Interrupt Controller Command Port Decoder

This block is the software-facing front end of an eight-line priority interrupt controller. A processor reaches it through two byte-wide addresses selected by a one-bit address, using single-cycle write and read strobes. The block runs the multi-word initialization sequence. It decodes operation commands for end-of-interrupt, priority rotation, polling and register-read selection, and it returns registered read data. That data is either the request, in-service or mask register, or the result of a poll.

A separate priority core keeps the request and in-service registers and arbitrates between the lines. This block sends the core its configuration: the interrupt mask, the vector base, the mode flags and the rotation base. It also sends a one-cycle clear for a single in-service bit, a poll acknowledge and a controller-clear pulse for initialization. In return it reads the core's request and in-service vectors and the core's current winning line. A trigger-mode register is loaded through its own write port. Only the bits enabled by a fixed writable-bit parameter can be written.

Top module: `pic_cmd_port`

## Requirements
- R1: After reset, every output is zero: mask, vector base, mode flags, rotation base, trigger mode, read data and all pulses.
- R2: A write to address 0 with data bit 4 set starts initialization. It clears the mask, vector base, rotation base, all mode flags, read-select and poll. It records data bit 1 as single mode and data bit 0 as fourth-word-needed. It pulses `core_clear` for one cycle and leaves the trigger-mode register unchanged.
- R3: The next address-1 write after R2 loads data bits 7:3 into the vector base. The sequence then moves to the cascade word if single mode is off. If single mode is on, it moves to the fourth word when fourth-word-needed is set, and to normal operation otherwise.
- R4: A cascade word changes no output. The sequence then moves to the fourth word if fourth-word-needed is set, and to normal operation otherwise.
- R5: In a fourth word, data bit 4 sets special fully nested mode and bit 1 sets auto-EOI, and the sequence returns to normal. In normal operation an address-1 write loads the mask.
- R6: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. When bit 1 is set, bit 0 is loaded into read-select (1 selects in-service, 0 selects request). When bit 6 is set, bit 5 is loaded into special mask.
- R7: An address-0 write with bits 4 and 3 clear is an operation command whose code is data bits 7:5. Codes 0 and 4 load rotate-on-auto-EOI from code bit 2.
- R8: Code 1 is a non-specific EOI. It clears the first set in-service bit in the order rotation base, base+1, and so on modulo 8, and does nothing if no in-service bit is set. Code 5 does the same and also sets the rotation base to (cleared line + 1) mod 8.
- R9: Code 3 clears in-service line data bits 2:0. Code 7 does the same and sets the rotation base to (line + 1) mod 8. Code 6 sets the rotation base to (data bits 2:0 + 1) mod 8. Code 2 has no effect.
- R10: A read while poll is armed returns 0x80 OR the core's winning line and pulses `ack` with that line, or returns 0 with no `ack` if the core has no winner. Either way the read disarms poll.
- R11: A read without poll returns the in-service or request vector at address 0, as read-select chooses, and the mask at address 1. Read data appears the cycle after the read strobe.
- R12: A write on the trigger-mode port stores its data ANDed with `TM_WRITABLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register address |
| wr | input | 1 | Write strobe, one cycle |
| rd | input | 1 | Read strobe, one cycle |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| tm_wr | input | 1 | Trigger-mode register write strobe |
| tm_din | input | 8 | Trigger-mode write data |
| core_irr | input | 8 | Request vector from the priority core |
| core_isr | input | 8 | In-service vector from the priority core |
| core_hit | input | 1 | Core has a winning request |
| core_line | input | 3 | Core's winning line |
| mask | output | 8 | Interrupt mask |
| vec_base | output | 5 | Vector base (vector bits 7:3) |
| single_mode | output | 1 | Single-controller mode |
| sfnm | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Auto-EOI mode |
| rot_aeoi | output | 1 | Rotate on auto-EOI |
| special_mask | output | 1 | Special mask mode |
| rot_base | output | 3 | Line with the highest priority |
| isr_clr | output | 8 | One-cycle in-service clear, one-hot or zero |
| ack | output | 1 | One-cycle poll acknowledge |
| ack_line | output | 3 | Line acknowledged by the poll |
| core_clear | output | 1 | One-cycle controller clear on initialization |
| trig_mode | output | 8 | Trigger-mode register |

## Verification
The bound checker tests these rules on every cycle:
- An in-service clear is never more than one-hot.
- An initialization write is always followed by the controller-clear pulse and a zero mask and rotation base.
- A normal-mode address-1 write always lands in the mask.
- A poll acknowledge always matches the read data and never repeats on the next cycle.
- No trigger-mode bit outside the writable set is ever high.

The sequencing of the initialization words depends on the flags given in the first word, so only the bench's scenarios can show it. The same holds for the choice of in-service bit under a rotated base, the no-op cases (empty in-service, command code 2, disabled mode-command fields) and the read-select multiplexing.

// File: rtl/pic_cmd_port.sv
`timescale 1ns/1ps
module pic_cmd_port #(
  parameter logic [7:0] TM_WRITABLE = 8'hDE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic       tm_wr,
  input  logic [7:0] tm_din,
  input  logic [7:0] core_irr,
  input  logic [7:0] core_isr,
  input  logic       core_hit,
  input  logic [2:0] core_line,
  output logic [7:0] mask,
  output logic [4:0] vec_base,
  output logic       single_mode,
  output logic       sfnm,
  output logic       auto_eoi,
  output logic       rot_aeoi,
  output logic       special_mask,
  output logic [2:0] rot_base,
  output logic [7:0] isr_clr,
  output logic       ack,
  output logic [2:0] ack_line,
  output logic       core_clear,
  output logic [7:0] trig_mode
);

  typedef enum logic [1:0] {PH_RUN, PH_W2, PH_W3, PH_W4} phase_t;
  phase_t phase;

  logic need_w4, rsel, poll;

  wire       wr0  = wr & ~addr;
  wire       wr1  = wr & addr;
  wire       icw1 = wr0 & din[4];
  wire       ocw3 = wr0 & ~din[4] & din[3];
  wire       ocw2 = wr0 & ~din[4] & ~din[3];
  wire [2:0] code = din[7:5];
  wire [2:0] lsel = din[2:0];

  logic       ns_hit;
  logic [2:0] ns_line;
  always_comb begin
    ns_hit  = 1'b0;
    ns_line = 3'd0;
    for (int k = 7; k >= 0; k--) begin
      logic [2:0] idx;
      idx = rot_base + 3'(k);
      if (core_isr[idx]) begin
        ns_hit  = 1'b1;
        ns_line = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase        <= PH_RUN;
      need_w4      <= 1'b0;
      single_mode  <= 1'b0;
      mask         <= 8'h00;
      vec_base     <= 5'd0;
      sfnm         <= 1'b0;
      auto_eoi     <= 1'b0;
      rot_aeoi     <= 1'b0;
      special_mask <= 1'b0;
      rot_base     <= 3'd0;
      rsel         <= 1'b0;
      poll         <= 1'b0;
      isr_clr      <= 8'h00;
      ack          <= 1'b0;
      ack_line     <= 3'd0;
      core_clear   <= 1'b0;
      dout         <= 8'h00;
    end else begin
      isr_clr    <= 8'h00;
      ack        <= 1'b0;
      core_clear <= 1'b0;

      if (icw1) begin
        phase        <= PH_W2;
        need_w4      <= din[0];
        single_mode  <= din[1];
        mask         <= 8'h00;
        vec_base     <= 5'd0;
        sfnm         <= 1'b0;
        auto_eoi     <= 1'b0;
        rot_aeoi     <= 1'b0;
        special_mask <= 1'b0;
        rot_base     <= 3'd0;
        rsel         <= 1'b0;
        poll         <= 1'b0;
        core_clear   <= 1'b1;
      end else if (ocw3) begin
        if (din[2]) poll <= 1'b1;
        if (din[1]) rsel <= din[0];
        if (din[6]) special_mask <= din[5];
      end else if (ocw2) begin
        case (code)
          3'd0, 3'd4: rot_aeoi <= code[2];
          3'd1, 3'd5: if (ns_hit) begin
            isr_clr <= 8'h01 << ns_line;
            if (code[2]) rot_base <= ns_line + 3'd1;
          end
          3'd3: isr_clr <= 8'h01 << lsel;
          3'd6: rot_base <= lsel + 3'd1;
          3'd7: begin
            isr_clr  <= 8'h01 << lsel;
            rot_base <= lsel + 3'd1;
          end
          default: ;
        endcase
      end else if (wr1) begin
        case (phase)
          PH_RUN: mask <= din;
          PH_W2: begin
            vec_base <= din[7:3];
            if (!single_mode)  phase <= PH_W3;
            else if (need_w4)  phase <= PH_W4;
            else               phase <= PH_RUN;
          end
          PH_W3: phase <= need_w4 ? PH_W4 : PH_RUN;
          PH_W4: begin
            sfnm     <= din[4];
            auto_eoi <= din[1];
            phase    <= PH_RUN;
          end
          default: phase <= PH_RUN;
        endcase
      end

      if (rd) begin
        if (poll) begin
          poll     <= 1'b0;
          ack      <= core_hit;
          ack_line <= core_line;
          dout     <= core_hit ? {5'b10000, core_line} : 8'h00;
        end else if (!addr) begin
          dout <= rsel ? core_isr : core_irr;
        end else begin
          dout <= mask;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     trig_mode <= 8'h00;
    else if (tm_wr) trig_mode <= tm_din & TM_WRITABLE;
  end

endmodule

// File: rtl/pic_cmd_port_chk.sv
`timescale 1ns/1ps
module pic_cmd_port_chk #(
  parameter logic [7:0] TM_WRITABLE = 8'hDE
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr,
  input logic       addr,
  input logic [7:0] din,
  input logic [1:0] phase,
  input logic [7:0] mask,
  input logic [2:0] rot_base,
  input logic [7:0] isr_clr,
  input logic       ack,
  input logic [2:0] ack_line,
  input logic [7:0] dout,
  input logic       core_clear,
  input logic [7:0] trig_mode
);

  p_eoi_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_clr));

  p_init_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr && din[4]) |=> (core_clear && mask == 8'h00 && rot_base == 3'd0));

  p_run_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr && phase == 2'd0) |=> (mask == $past(din)));

  p_poll_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (dout[7] && dout[2:0] == ack_line));

  p_poll_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_trig_fixed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode & ~TM_WRITABLE) == 8'h00);

endmodule

bind pic_cmd_port pic_cmd_port_chk #(.TM_WRITABLE(TM_WRITABLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .din(din), .phase(phase),
  .mask(mask), .rot_base(rot_base), .isr_clr(isr_clr), .ack(ack),
  .ack_line(ack_line), .dout(dout), .core_clear(core_clear), .trig_mode(trig_mode)
);

// File: tb/sim_pic_cmd_port.sv
`timescale 1ns/1ps
module sim_pic_cmd_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr = 1'b0, wr = 1'b0, rd = 1'b0, tm_wr = 1'b0;
  logic [7:0] din = 8'h00, tm_din = 8'h00, core_irr = 8'h00, core_isr = 8'h00;
  logic core_hit = 1'b0;
  logic [2:0] core_line = 3'd0;
  logic [7:0] dout, mask, isr_clr, trig_mode;
  logic [4:0] vec_base;
  logic single_mode, sfnm, auto_eoi, rot_aeoi, special_mask, ack, core_clear;
  logic [2:0] rot_base, ack_line;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pic_cmd_port u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic a, logic [7:0] d);
    @(negedge clk); addr = a; din = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 mask", mask, 0);
    check("R1 flags", {single_mode, sfnm, auto_eoi, rot_aeoi, special_mask}, 0);
    check("R1 base", {vec_base, rot_base}, 0);
    check("R1 pulses", {isr_clr, ack, core_clear}, 0);
    check("R1 dout/trig", {dout, trig_mode}, 0);
  endtask

  task automatic t_init_full;
    wreg(1'b0, 8'h11);
    check("R2 core_clear", core_clear, 1);
    check("R2 single", single_mode, 0);
    wreg(1'b1, 8'h48);
    check("R3 vec_base", vec_base, 5'd9);
    wreg(1'b1, 8'h04);
    check("R4 cascade ignored", {vec_base, mask, sfnm, auto_eoi}, {5'd9, 8'h00, 2'b00});
    wreg(1'b1, 8'h12);
    check("R5 icw4 flags", {sfnm, auto_eoi}, 2'b11);
    wreg(1'b1, 8'hA5);
    check("R5 mask load", mask, 8'hA5);
  endtask

  task automatic t_init_short;
    wreg(1'b0, 8'h12);
    check("R2 mask cleared", mask, 0);
    check("R2 flags cleared", {sfnm, auto_eoi, single_mode}, 3'b001);
    wreg(1'b1, 8'h20);
    check("R3 single base", vec_base, 5'd4);
    wreg(1'b1, 8'h3C);
    check("R3 single no icw4 -> mask", mask, 8'h3C);
    wreg(1'b0, 8'h13);
    wreg(1'b1, 8'hF8);
    wreg(1'b1, 8'h02);
    check("R3 single icw4 aeoi", {sfnm, auto_eoi, mask}, {2'b01, 8'h00});
    wreg(1'b1, 8'h77);
    check("R5 mask after single icw4", mask, 8'h77);
    wreg(1'b0, 8'h10);
    wreg(1'b1, 8'h08);
    wreg(1'b1, 8'h55);
    check("R4 cascade then normal", mask, 8'h00);
    wreg(1'b1, 8'h66);
    check("R4 mask after cascade", mask, 8'h66);
  endtask

  task automatic t_ocw3;
    wreg(1'b0, 8'h68);
    check("R6 special mask set", special_mask, 1);
    wreg(1'b0, 8'h28);
    check("R6 special mask hold", special_mask, 1);
    wreg(1'b0, 8'h48);
    check("R6 special mask clear", special_mask, 0);
    core_isr = 8'h81; core_irr = 8'h42;
    wreg(1'b0, 8'h0B);
    rreg(1'b0);
    check("R11 isr read", dout, 8'h81);
    wreg(1'b0, 8'h09);
    rreg(1'b0);
    check("R6 rsel hold", dout, 8'h81);
    wreg(1'b0, 8'h0A);
    rreg(1'b0);
    check("R11 irr read", dout, 8'h42);
    rreg(1'b1);
    check("R11 mask read", dout, 8'h66);
  endtask

  task automatic t_ocw2;
    wreg(1'b0, 8'h80);
    check("R7 rot_aeoi set", rot_aeoi, 1);
    wreg(1'b0, 8'h00);
    check("R7 rot_aeoi clear", rot_aeoi, 0);
    wreg(1'b0, 8'hC4);
    check("R9 set base", rot_base, 3'd5);
    core_isr = 8'h44;
    wreg(1'b0, 8'h20);
    check("R8 nseoi rotated order", isr_clr, 8'h40);
    core_isr = 8'h04;
    wreg(1'b0, 8'hA0);
    check("R8 nseoi rotate clr", isr_clr, 8'h04);
    check("R8 nseoi rotate base", rot_base, 3'd3);
    core_isr = 8'h00;
    wreg(1'b0, 8'hA0);
    check("R8 empty isr", {isr_clr, 5'd0, rot_base}, {8'h00, 5'd0, 3'd3});
    wreg(1'b0, 8'h67);
    check("R9 specific eoi", isr_clr, 8'h80);
    wreg(1'b0, 8'hE1);
    check("R9 specific rotate", {isr_clr, 5'd0, rot_base}, {8'h02, 5'd0, 3'd2});
    wreg(1'b0, 8'h43);
    check("R9 code2 noop", {isr_clr, mask, 5'd0, rot_base, rot_aeoi}, {8'h00, 8'h66, 5'd0, 3'd2, 1'b0});
  endtask

  task automatic t_poll;
    core_hit = 1'b1; core_line = 3'd5;
    wreg(1'b0, 8'h0C);
    rreg(1'b0);
    check("R10 poll data", dout, 8'h85);
    check("R10 poll ack", {ack, ack_line}, {1'b1, 3'd5});
    rreg(1'b1);
    check("R10 poll disarmed", {dout, 7'd0, ack}, {8'h66, 8'h00});
    core_hit = 1'b0;
    wreg(1'b0, 8'h0C);
    rreg(1'b0);
    check("R10 poll empty", {dout, 7'd0, ack}, 16'h0000);
  endtask

  task automatic t_trig;
    @(negedge clk); tm_din = 8'hFF; tm_wr = 1'b1;
    @(negedge clk); tm_wr = 1'b0;
    check("R12 trig masked", trig_mode, 8'hDE);
    wreg(1'b0, 8'h11);
    check("R2 trig kept", trig_mode, 8'hDE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_full();
    t_init_short();
    t_ocw3();
    t_ocw2();
    t_poll();
    t_trig();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule